// File: doc/BRIEF.md
# CD Sector Write and Decode Controller

This block sits on the drive side of a CD data path. Each byte from the drive arrives with a tag that gives its position inside the sector. Two mode inputs choose what happens to the stream. In write mode, every byte goes to an external buffer RAM at a 16-bit write address that advances by one after each byte. In monitor mode, nothing is stored and only the four header bytes of each sector are captured.

The byte tagged with offset 12 marks the sync of the following sector. On that byte the header registers are declared stale and the decode flag is set inactive. In write mode the block also remembers where the sector that has just ended began, which is 2352 bytes behind the current write address. When decoding is enabled, a decode timer starts.

When the timer expires, the header registers become valid, the decode flag is raised (active-low) and the CRC-ok status bit is set. In write mode the four header bytes are first fetched from the buffer, starting at the remembered block start. These four reads finish before the flag asserts, so the header value is already stable when the interrupt is seen.

Top module: `cdsec_decode_ctrl`

## Requirements
- R1: After reset: `wr_addr`=0, `blk_ptr`=0, `head_bytes`=0, `hdr_stale`=1, `dec_irq_n`=1, `crc_ok`=0, and `ram_we`/`ram_re` are low.
- R2: When `in_valid`, `dec_en` and `wr_req` are all 1, `ram_we` is 1 in that same cycle, with `ram_waddr` equal to the low BUF_AW bits of `wr_addr` and `ram_wdata` equal to `in_byte`. From the next cycle `wr_addr` is one higher: the low byte carries into the high byte, and 0xFFFF wraps to 0x0000.
- R3: When `in_valid` is 0, or `dec_en` is 0, or `wr_req` is 0, no RAM write happens and `wr_addr` keeps its value.
- R4: `wa_load`=1 places `wa_load_val` in `wr_addr` from the next cycle. It takes precedence over the increment, while the byte of that cycle is still written at the old address.
- R5: A valid byte whose `in_offset` is 12 (the sync) sets `hdr_stale`=1 and `dec_irq_n`=1 from the next cycle, whatever the mode.
- R6: On a sync byte with `dec_en`=1 and `wr_req`=1, `blk_ptr` takes the value `wr_addr` − 2352 modulo 2^16. On a sync byte in any other mode, `blk_ptr` is unchanged.
- R7: A sync byte with `dec_en`=1 starts a decode of DECODE_SLOTS×SLOT_CLKS cycles (default 9408). In monitor mode (`wr_req`=0) the decode completes exactly that many cycles after the sync byte's clock edge. On completion `dec_irq_n` goes to 0 and `hdr_stale` goes to 0.
- R8: In monitor mode (`dec_en`=1, `wr_req`=0), the valid bytes at offsets 12, 13, 14 and 15 are stored as header bytes 0 to 3. Header byte k sits in `head_bytes[8k+7:8k]`.
- R9: In write mode the decode completes 5 cycles later than in R7. Before completion `ram_re` pulses four times, with `ram_raddr` equal to `blk_ptr`+0, +1, +2, +3 wrapped to the buffer size, and the returned bytes become header bytes 0 to 3. The RAM returns read data one cycle after the read.
- R10: A sync byte with `dec_en`=1 that arrives while a decode is running restarts the full decode time from the new sync.
- R11: A sync byte with `dec_en`=0 starts no decode, so `dec_irq_n` stays 1.
- R12: Decode completion sets `crc_ok` to 1. Once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the drive side |
| in_byte | input | 8 | Sector byte |
| in_offset | input | 12 | Position of the byte inside the sector |
| dec_en | input | 1 | Decode enable |
| wr_req | input | 1 | Buffer write request |
| wa_load | input | 1 | Load the write address |
| wa_load_val | input | 16 | Value for the write address |
| wr_addr | output | 16 | Current write address |
| blk_ptr | output | 16 | Start of the last completed sector block |
| ram_we | output | 1 | Buffer write strobe |
| ram_waddr | output | 10 | Buffer write address |
| ram_wdata | output | 8 | Buffer write data |
| ram_re | output | 1 | Buffer read strobe |
| ram_raddr | output | 10 | Buffer read address |
| ram_rdata | input | 8 | Buffer read data, one cycle after `ram_re` |
| head_bytes | output | 32 | Header bytes 0 to 3, byte 0 in the low bits |
| hdr_stale | output | 1 | 1 while the header registers are not valid |
| dec_irq_n | output | 1 | Decode flag, active low |
| crc_ok | output | 1 | Set on decode completion |

## Verification
The assertions assume that `wa_load_val` and the mode inputs are stable in the cycles in which they are sampled. They also assume that `ram_rdata` follows the one-cycle read latency. The bench RAM model provides exactly that latency. The bench changes inputs only on the falling edge, and never changes the mode in the middle of a header fetch, so each fetch runs under a single mode. Sync bytes are sent only at chosen points, and this keeps every decode window separate, apart from the one restart that R10 is about.

// File: rtl/cdsec_pkg.sv
package cdsec_pkg;
  localparam int unsigned SECTOR_BYTES = 2352;
  localparam int unsigned SYNC_OFFSET  = 12;
  localparam int unsigned HDR_BYTES    = 4;

  // Write address step: low byte first, carry into high byte
  function automatic logic [15:0] wa_step(input logic [15:0] wa);
    logic [7:0] lo;
    logic [7:0] hi;
    lo = wa[7:0] + 8'd1;
    hi = wa[15:8] + {7'd0, (lo == 8'd0)};
    return {hi, lo};
  endfunction

  // Block start: one full sector behind the write address
  function automatic logic [15:0] blk_start(input logic [15:0] wa);
    return wa - 16'(SECTOR_BYTES);
  endfunction
endpackage

// File: rtl/cdsec_wr_path.sv
module cdsec_wr_path #(
  parameter int unsigned BUF_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              dec_en,
  input  logic              wr_req,
  input  logic              wa_load,
  input  logic [15:0]       wa_load_val,
  output logic [15:0]       wr_addr,
  output logic              ram_we,
  output logic [BUF_AW-1:0] ram_waddr,
  output logic [7:0]        ram_wdata
);
  import cdsec_pkg::*;

  logic [15:0] wa_q;
  logic        wr_evt;

  assign wr_evt    = in_valid && dec_en && wr_req;
  assign ram_we    = wr_evt;
  assign ram_waddr = wa_q[BUF_AW-1:0];
  assign ram_wdata = in_byte;
  assign wr_addr   = wa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
    end else if (wa_load) begin
      wa_q <= wa_load_val;
    end else if (wr_evt) begin
      wa_q <= wa_step(wa_q);
    end
  end
endmodule

// File: rtl/cdsec_dec_timer.sv
module cdsec_dec_timer #(
  parameter int unsigned SLOTS     = 9408,
  parameter int unsigned SLOT_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire,
  output logic busy
);
  localparam int unsigned CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic          tick;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  generate
    if (SLOT_CLKS > 1) begin : g_div
      localparam int unsigned DW = $clog2(SLOT_CLKS);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else if (start || div_q == DW'(SLOT_CLKS - 1)) begin
          div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
      assign tick = (div_q == DW'(SLOT_CLKS - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(SLOTS - 1);
    end else if (busy_q && tick) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign expire = busy_q && tick && (cnt_q == '0) && !start;
  assign busy   = busy_q;
endmodule

// File: rtl/cdsec_hdr_unit.sv
module cdsec_hdr_unit #(
  parameter int unsigned BUF_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic              abort,
  input  logic [15:0]       blk_ptr,
  input  logic              mon_we,
  input  logic [1:0]        mon_idx,
  input  logic [7:0]        mon_byte,
  input  logic [7:0]        ram_rdata,
  output logic              ram_re,
  output logic [BUF_AW-1:0] ram_raddr,
  output logic [31:0]       head_bytes,
  output logic              fetch_done
);
  import cdsec_pkg::*;

  localparam logic [2:0] LAST_IDX = 3'(HDR_BYTES);

  logic [3:0][7:0] head_q;
  logic            fetching_q;
  logic [2:0]      idx_q;

  assign ram_re     = fetching_q && (idx_q < LAST_IDX);
  assign ram_raddr  = BUF_AW'(blk_ptr + 16'(idx_q));
  assign fetch_done = fetching_q && (idx_q == LAST_IDX) && !abort;
  assign head_bytes = head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetching_q <= 1'b0;
      idx_q      <= '0;
    end else if (abort) begin
      fetching_q <= 1'b0;
      idx_q      <= '0;
    end else if (fetch_go) begin
      fetching_q <= 1'b1;
      idx_q      <= '0;
    end else if (fetching_q) begin
      if (idx_q == LAST_IDX) fetching_q <= 1'b0;
      else                   idx_q      <= idx_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else begin
      if (fetching_q && !abort && idx_q != 3'd0) begin
        head_q[2'(idx_q - 3'd1)] <= ram_rdata;
      end
      if (mon_we) begin
        head_q[mon_idx] <= mon_byte;
      end
    end
  end
endmodule

// File: rtl/cdsec_decode_ctrl.sv
module cdsec_decode_ctrl #(
  parameter int unsigned BUF_AW       = 10,
  parameter int unsigned OFS_W        = 12,
  parameter int unsigned DECODE_SLOTS = 2352 * 4,
  parameter int unsigned SLOT_CLKS    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [OFS_W-1:0]  in_offset,
  input  logic              dec_en,
  input  logic              wr_req,
  input  logic              wa_load,
  input  logic [15:0]       wa_load_val,
  output logic [15:0]       wr_addr,
  output logic [15:0]       blk_ptr,
  output logic              ram_we,
  output logic [BUF_AW-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              ram_re,
  output logic [BUF_AW-1:0] ram_raddr,
  input  logic [7:0]        ram_rdata,
  output logic [31:0]       head_bytes,
  output logic              hdr_stale,
  output logic              dec_irq_n,
  output logic              crc_ok
);
  import cdsec_pkg::*;

  localparam logic [OFS_W-1:0] HDR_FIRST = OFS_W'(SYNC_OFFSET);
  localparam logic [OFS_W-1:0] HDR_LAST  = OFS_W'(SYNC_OFFSET + HDR_BYTES - 1);

  logic        sync_evt;
  logic        tmr_start;
  logic        tmr_expire;
  logic        tmr_busy;
  logic        fetch_go;
  logic        fetch_done;
  logic        finish_evt;
  logic        mon_we;
  logic [1:0]  mon_idx;
  logic [15:0] ptr_q;
  logic        stale_q;
  logic        irq_n_q;
  logic        crc_q;

  assign sync_evt   = in_valid && (in_offset == HDR_FIRST);
  assign tmr_start  = sync_evt && dec_en;
  assign fetch_go   = tmr_expire && wr_req;
  assign finish_evt = (tmr_expire && !wr_req) || fetch_done;
  assign mon_we     = in_valid && dec_en && !wr_req &&
                      (in_offset >= HDR_FIRST) && (in_offset <= HDR_LAST);
  assign mon_idx    = 2'(in_offset - HDR_FIRST);

  cdsec_wr_path #(.BUF_AW(BUF_AW)) wr_path_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .dec_en(dec_en), .wr_req(wr_req), .wa_load(wa_load),
    .wa_load_val(wa_load_val), .wr_addr(wr_addr), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  cdsec_dec_timer #(.SLOTS(DECODE_SLOTS), .SLOT_CLKS(SLOT_CLKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .expire(tmr_expire),
    .busy(tmr_busy)
  );

  cdsec_hdr_unit #(.BUF_AW(BUF_AW)) hdr_i (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .abort(tmr_start),
    .blk_ptr(ptr_q), .mon_we(mon_we), .mon_idx(mon_idx), .mon_byte(in_byte),
    .ram_rdata(ram_rdata), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .head_bytes(head_bytes), .fetch_done(fetch_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (sync_evt && dec_en && wr_req) begin
      ptr_q <= blk_start(wr_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_q <= 1'b1;
      irq_n_q <= 1'b1;
      crc_q   <= 1'b0;
    end else if (sync_evt) begin
      stale_q <= 1'b1;
      irq_n_q <= 1'b1;
    end else if (finish_evt) begin
      stale_q <= 1'b0;
      irq_n_q <= 1'b0;
      crc_q   <= 1'b1;
    end
  end

  assign blk_ptr   = ptr_q;
  assign hdr_stale = stale_q;
  assign dec_irq_n = irq_n_q;
  assign crc_ok    = crc_q;
endmodule

// File: rtl/cdsec_decode_ctrl_chk.sv
module cdsec_decode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wa_load,
  input logic [15:0] wa_load_val,
  input logic [15:0] wr_addr,
  input logic        ram_we,
  input logic        ram_re,
  input logic        hdr_stale,
  input logic        dec_irq_n,
  input logic        crc_ok,
  input logic        sync_evt,
  input logic        finish_evt
);
  // R2
  wa_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && !wa_load |=> wr_addr == $past(wr_addr) + 16'd1);

  // R3
  wa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we && !wa_load |=> $stable(wr_addr));

  // R4
  wa_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wa_load |=> wr_addr == $past(wa_load_val));

  // R5
  sync_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> hdr_stale && dec_irq_n);

  // R7
  finish_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt && !sync_evt |=> !dec_irq_n && !hdr_stale && crc_ok);

  // R7
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dec_irq_n) |-> !hdr_stale);

  // R9
  fetch_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> hdr_stale);

  // R12
  crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |=> crc_ok);
endmodule

bind cdsec_decode_ctrl cdsec_decode_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wa_load(wa_load), .wa_load_val(wa_load_val),
  .wr_addr(wr_addr), .ram_we(ram_we), .ram_re(ram_re), .hdr_stale(hdr_stale),
  .dec_irq_n(dec_irq_n), .crc_ok(crc_ok), .sync_evt(sync_evt),
  .finish_evt(finish_evt)
);

// File: tb/cdsec_decode_ctrl_tb.sv
`timescale 1ns/1ps
module cdsec_decode_ctrl_tb_top;
  localparam int DEC  = 2352 * 4;
  localparam int SECT = 2352;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [11:0] in_offset = '0;
  logic        dec_en = 1'b0;
  logic        wr_req = 1'b0;
  logic        wa_load = 1'b0;
  logic [15:0] wa_load_val = '0;
  logic [15:0] wr_addr, blk_ptr;
  logic        ram_we, ram_re;
  logic [9:0]  ram_waddr, ram_raddr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic [31:0] head_bytes;
  logic        hdr_stale, dec_irq_n, crc_ok;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] mem [0:1023];
  logic       rec_clr = 1'b0;
  logic [9:0] rec [0:7];
  int         rec_n = 0;

  always #2.5 clk = ~clk;

  cdsec_decode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_offset(in_offset), .dec_en(dec_en), .wr_req(wr_req),
    .wa_load(wa_load), .wa_load_val(wa_load_val), .wr_addr(wr_addr),
    .blk_ptr(blk_ptr), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .ram_rdata(ram_rdata), .head_bytes(head_bytes), .hdr_stale(hdr_stale),
    .dec_irq_n(dec_irq_n), .crc_ok(crc_ok)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_raddr];
    if (rec_clr) rec_n <= 0;
    else if (ram_re && rec_n < 8) begin
      rec[rec_n] <= ram_raddr;
      rec_n <= rec_n + 1;
    end
  end

  // {load, load value, valid, dec_en, wr_req, byte, exp write, exp addr after}
  localparam logic [44:0] VEC [0:8] = '{
    {1'b1, 16'h00FE, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 16'h00FE},
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hA1, 1'b1, 16'h00FF},
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hB2, 1'b1, 16'h0100},
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 8'hC3, 1'b0, 16'h0100},
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'hD4, 1'b0, 16'h0100},
    {1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'hE5, 1'b0, 16'h0100},
    {1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 16'hFFFF},
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b1, 16'h0000},
    {1'b1, 16'h1234, 1'b1, 1'b1, 1'b1, 8'h77, 1'b1, 16'h1234}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic send(input logic [11:0] ofs, input logic [7:0] b,
                      input logic de, input logic wq);
    dec_en = de; wr_req = wq;
    in_valid = 1'b1; in_offset = ofs; in_byte = b;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_wa(input logic [15:0] v);
    wa_load = 1'b1; wa_load_val = v;
    @(posedge clk); @(negedge clk);
    wa_load = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] exp_wa;
    exp_wa = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 wr_addr", {16'd0, wr_addr}, 32'd0);
    check("R1 blk_ptr", {16'd0, blk_ptr}, 32'd0);
    check("R1 head", head_bytes, 32'd0);
    check("R1 flags", {29'd0, hdr_stale, dec_irq_n, crc_ok}, 32'b110);
    check("R1 ram strobes", {30'd0, ram_we, ram_re}, 32'd0);

    // R2 R3 R4 table walk
    for (int i = 0; i < 9; i++) begin
      logic        v_ld, v_vl, v_de, v_wq, v_we;
      logic [15:0] v_lv, v_wa;
      logic [7:0]  v_b;
      {v_ld, v_lv, v_vl, v_de, v_wq, v_b, v_we, v_wa} = VEC[i];
      wa_load = v_ld; wa_load_val = v_lv;
      in_valid = v_vl; dec_en = v_de; wr_req = v_wq; in_byte = v_b;
      in_offset = 12'd0;
      #1;
      check($sformatf("R2/R3 write strobe vec%0d", i), {31'd0, ram_we}, {31'd0, v_we});
      if (v_we) begin
        check($sformatf("R2 write addr vec%0d", i), {22'd0, ram_waddr}, {22'd0, exp_wa[9:0]});
        check($sformatf("R2 write data vec%0d", i), {24'd0, ram_wdata}, {24'd0, v_b});
      end
      @(posedge clk); @(negedge clk);
      wa_load = 1'b0; in_valid = 1'b0;
      check($sformatf("R2/R3/R4 wr_addr vec%0d", i), {16'd0, wr_addr}, {16'd0, v_wa});
      exp_wa = v_wa;
    end

    // R6 pointer wrap below zero, R5 flags on sync
    load_wa(16'h0005);
    send(12'd12, 8'h01, 1'b1, 1'b1);
    check("R6 ptr wrap", {16'd0, blk_ptr}, {16'd0, 16'h0005 - 16'(SECT)});
    check("R5 sync flags", {30'd0, hdr_stale, dec_irq_n}, 32'b11);

    // R8 monitor capture; R6 pointer kept; R7 timing
    rec_clr = 1'b1; @(negedge clk); rec_clr = 1'b0;
    send(12'd12, 8'h11, 1'b1, 1'b0);
    send(12'd13, 8'h22, 1'b1, 1'b0);
    send(12'd14, 8'h33, 1'b1, 1'b0);
    send(12'd15, 8'h44, 1'b1, 1'b0);
    check("R6 ptr unchanged in monitor", {16'd0, blk_ptr}, {16'd0, 16'hF6D5});
    check("R8 monitor header", head_bytes, 32'h44332211);
    wait_cyc(DEC - 4);
    check("R7 still busy at N-1", {30'd0, hdr_stale, dec_irq_n}, 32'b11);
    wait_cyc(1);
    check("R7 done at N", {29'd0, hdr_stale, dec_irq_n, crc_ok}, 32'b001);
    check("R8 no buffer reads", rec_n, 32'd0);

    // R9 write mode fetch with buffer wrap
    load_wa(16'd1022);
    send(12'd0, 8'hA0, 1'b1, 1'b1);
    send(12'd1, 8'hA1, 1'b1, 1'b1);
    send(12'd2, 8'hA2, 1'b1, 1'b1);
    send(12'd3, 8'hA3, 1'b1, 1'b1);
    load_wa(16'd1022 + 16'(SECT));
    rec_clr = 1'b1; @(negedge clk); rec_clr = 1'b0;
    send(12'd12, 8'h5C, 1'b1, 1'b1);
    check("R6 ptr from write addr", {16'd0, blk_ptr}, 32'd1022);
    check("R12 crc kept after sync", {31'd0, crc_ok}, 32'd1);
    wait_cyc(DEC + 4);
    check("R9 still busy at N+4", {30'd0, hdr_stale, dec_irq_n}, 32'b11);
    wait_cyc(1);
    check("R9 done at N+5", {30'd0, hdr_stale, dec_irq_n}, 32'b00);
    check("R9 fetched header", head_bytes, 32'hA3A2A1A0);
    check("R9 read count", rec_n, 32'd4);
    check("R9 read addr0", {22'd0, rec[0]}, 32'd1022);
    check("R9 read addr1", {22'd0, rec[1]}, 32'd1023);
    check("R9 read addr2", {22'd0, rec[2]}, 32'd0);
    check("R9 read addr3", {22'd0, rec[3]}, 32'd1);

    // R10 restart on a second sync
    send(12'd12, 8'h99, 1'b1, 1'b0);
    wait_cyc(4000);
    send(12'd12, 8'h98, 1'b1, 1'b0);
    wait_cyc(DEC - 1);
    check("R10 restarted, busy at N-1", {31'd0, dec_irq_n}, 32'd1);
    wait_cyc(1);
    check("R10 done at N after restart", {31'd0, dec_irq_n}, 32'd0);

    // R11 sync without decode enable
    send(12'd12, 8'h55, 1'b0, 1'b0);
    check("R11 flags inactive", {30'd0, hdr_stale, dec_irq_n}, 32'b11);
    wait_cyc(DEC + 10);
    check("R11 no completion", {31'd0, dec_irq_n}, 32'd1);
    check("R12 crc sticky", {31'd0, crc_ok}, 32'd1);

    finish_run();
  end
endmodule